// File: doc/BRIEF.md
# Four-channel DMA mode and mask controller

This block keeps the programming state of a group of four DMA channels. Software writes
bytes to a command port. A mask command turns request gating on or off for one channel.
A mode command stores one channel's six-bit mode field. The field holds the transfer
mode, the address direction, the autoinitialize enable and the transfer type. The arbiter
sees only the masked requests. The transfer engine reads the per-channel mode and the
read/write strobe enables.

Each channel also holds a base and a current value for its address and its count. A load
port writes the base and current copies together. A per-channel acknowledge strobe steps
the current address up or down and steps the count down. When a transfer is acknowledged
while the count is zero, the channel reports terminal count. It then either reloads from
its base values (autoinitialize) or stops and masks itself.

Each channel runs a two-state machine:
- `CH_ARMED`: acknowledges step the channel.
- `CH_EXPIRED`: acknowledges are ignored.

Its transitions are:
- `ARM_TO_EXPIRED`: terminal count with autoinitialize off.
- `EXPIRED_TO_ARMED`: any load-port write to that channel.
- `ANY_TO_ARMED`: reset or master clear.

Top module: `dma4_mode_ctrl`

## Requirements
- R1: After reset or a one-cycle `mclr` pulse, all four mask bits are set, so `dreq_masked` is 0. Every mode field is 0 (demand, increment, autoinitialize off, verify). Every channel is in `CH_ARMED`.
- R2: A mask command (`cmd_sel`=0) selects a channel with `cmd_data[1:0]`. `cmd_data[2]`=1 masks that channel and 0 unmasks it. The other three mask bits do not change.
- R3: `dreq_masked[i]` equals `dreq[i]` when channel i is unmasked, and 0 when it is masked.
- R4: A mode command (`cmd_sel`=1) selects a channel with `cmd_data[1:0]` and stores `cmd_data[7:2]` in that channel's mode. It appears on `ch_mode[6i+5:6i]` the next cycle. The field layout is: bits 5:4 mode (00 demand, 01 single, 10 reserved, 11 cascade), bit 3 decrement, bit 2 autoinitialize, bits 1:0 transfer type. The other channels' modes do not change.
- R5: A load-port write (`ld_is_cnt`=0 for address, 1 for count) stores `ld_data` into both the base and the current register of channel `ld_ch`. It takes priority over an acknowledge in the same cycle.
- R6: An acknowledge on a `CH_ARMED` channel with a nonzero count decrements the count by one. It moves the address by +1 when the decrement bit is 0, and by -1 when the decrement bit is 1.
- R7: An acknowledge on a `CH_ARMED` channel whose count is zero raises `tc[i]` for exactly the following cycle.
- R8: At terminal count with autoinitialize on, the current address and count are reloaded from their base values. The mask is not changed.
- R9: At terminal count with autoinitialize off, the count wraps to all ones and the address steps once. The channel's mask bit is set and the channel enters `CH_EXPIRED`. There, acknowledges change neither address, count nor `tc` until a load-port write to that channel.
- R10: `wr_en[i]` is high only for transfer type 01 and `rd_en[i]` only for type 10, and neither is high when the mode is cascade. Types 00 (verify) and 11 (illegal) give no strobe, though an illegal type is still stored in the mode field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mclr | input | 1 | Synchronous master clear |
| cmd_we | input | 1 | Command byte write strobe |
| cmd_sel | input | 1 | 0 = mask command, 1 = mode command |
| cmd_data | input | 8 | Command byte |
| ld_we | input | 1 | Load-port write strobe |
| ld_ch | input | 2 | Load-port channel |
| ld_is_cnt | input | 1 | 0 = address, 1 = count |
| ld_data | input | 16 | Load value |
| dack | input | 4 | Per-channel transfer acknowledge |
| dreq | input | 4 | Raw per-channel requests |
| dreq_masked | output | 4 | Requests after masking |
| ch_mode | output | 24 | Per-channel mode fields, 6 bits each |
| wr_en | output | 4 | I/O-to-memory strobe enable |
| rd_en | output | 4 | Memory-to-I/O strobe enable |
| tc | output | 4 | Terminal count pulse |
| cur_addr | output | 64 | Current addresses, 16 bits each |
| cur_cnt | output | 64 | Current counts, 16 bits each |

## Verification
The bench checks that a mask command touches only the selected channel; a design that
decoded the select as a mask or wrote all four bits would change neighbours. It sends an
acknowledge at count zero both with and without autoinitialize. A wrong design would miss
the reload, keep counting past terminal count, or leave the channel requesting. It also
sends a second acknowledge to an expired channel, which must not move the address. It
writes cascade and illegal transfer types, which must store the field but enable no
strobe, and it reads a decrementing address across a 0x2000 boundary.

// File: rtl/dma4_pkg.sv
package dma4_pkg;
    typedef enum logic [1:0] {
        XM_DEMAND  = 2'b00,
        XM_SINGLE  = 2'b01,
        XM_RSVD    = 2'b10,
        XM_CASCADE = 2'b11
    } xmode_e;

    typedef enum logic [1:0] {
        XT_VERIFY  = 2'b00,
        XT_WRITE   = 2'b01,
        XT_READ    = 2'b10,
        XT_ILLEGAL = 2'b11
    } xtype_e;

    typedef struct packed {
        xmode_e xmode;
        logic   dec;
        logic   autoinit;
        xtype_e xtype;
    } chmode_t;

    typedef enum logic {
        CMD_MASK = 1'b0,
        CMD_MODE = 1'b1
    } cmd_kind_e;

    typedef enum logic {
        CH_ARMED   = 1'b0,
        CH_EXPIRED = 1'b1
    } ch_state_e;

    localparam int MODE_W = $bits(chmode_t);
endpackage

// File: rtl/dma4_cmd_regs.sv
module dma4_cmd_regs
    import dma4_pkg::*;
#(
    parameter int NCH = 4,
    localparam int CH_W = $clog2(NCH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           mclr,
    input  logic           cmd_we,
    input  logic           cmd_sel,
    input  logic [7:0]     cmd_data,
    input  logic [NCH-1:0] stop,
    output logic [NCH-1:0] mask,
    output chmode_t        mode [NCH]
);
    logic [CH_W-1:0] sel;
    cmd_kind_e       kind;

    assign sel  = cmd_data[CH_W-1:0];
    assign kind = cmd_kind_e'(cmd_sel);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask <= '1;
            for (int i = 0; i < NCH; i++) mode[i] <= '0;
        end else if (mclr) begin
            mask <= '1;
            for (int i = 0; i < NCH; i++) mode[i] <= '0;
        end else begin
            if (cmd_we) begin
                unique case (kind)
                    CMD_MASK: mask[sel] <= cmd_data[2];
                    CMD_MODE: mode[sel] <= chmode_t'(cmd_data[7:2]);
                endcase
            end
            // a channel stopping at terminal count masks itself; this wins over a command
            for (int i = 0; i < NCH; i++) begin
                if (stop[i]) mask[i] <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/dma4_chan.sv
module dma4_chan
    import dma4_pkg::*;
#(
    parameter int AW  = 16,
    parameter int CW  = 16,
    parameter int LDW = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           mclr,
    input  logic           ld_we,
    input  logic           ld_is_cnt,
    input  logic [LDW-1:0] ld_data,
    input  logic           ack,
    input  logic           dec,
    input  logic           autoinit,
    output logic [AW-1:0]  cur_addr,
    output logic [CW-1:0]  cur_cnt,
    output logic           tc,
    output logic           stop,
    output logic           armed
);
    localparam logic [AW-1:0] A_ONE = AW'(1);
    localparam logic [CW-1:0] C_ONE = CW'(1);

    ch_state_e      state_q, state_d;
    logic [AW-1:0]  base_addr;
    logic [CW-1:0]  base_cnt;
    logic           step, at_zero;

    assign armed   = (state_q == CH_ARMED);
    assign step    = ack && armed && !ld_we && !mclr;
    assign at_zero = (cur_cnt == '0);
    assign stop    = step && at_zero && !autoinit;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_ARMED:   if (stop)  state_d = CH_EXPIRED;
            CH_EXPIRED: if (ld_we) state_d = CH_ARMED;
        endcase
        if (mclr) state_d = CH_ARMED;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_ARMED;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_addr <= '0;
            base_cnt  <= '0;
            cur_addr  <= '0;
            cur_cnt   <= '0;
            tc        <= 1'b0;
        end else begin
            tc <= step && at_zero;
            if (ld_we && !mclr) begin
                if (ld_is_cnt) begin
                    base_cnt <= ld_data[CW-1:0];
                    cur_cnt  <= ld_data[CW-1:0];
                end else begin
                    base_addr <= ld_data[AW-1:0];
                    cur_addr  <= ld_data[AW-1:0];
                end
            end else if (step) begin
                if (at_zero && autoinit) begin
                    cur_addr <= base_addr;
                    cur_cnt  <= base_cnt;
                end else begin
                    cur_cnt  <= cur_cnt - C_ONE;
                    cur_addr <= dec ? (cur_addr - A_ONE) : (cur_addr + A_ONE);
                end
            end
        end
    end
endmodule

// File: rtl/dma4_mode_ctrl.sv
module dma4_mode_ctrl
    import dma4_pkg::*;
#(
    parameter int NCH = 4,
    parameter int AW  = 16,
    parameter int CW  = 16,
    localparam int CH_W = $clog2(NCH),
    localparam int LDW  = (AW > CW) ? AW : CW
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  mclr,
    input  logic                  cmd_we,
    input  logic                  cmd_sel,
    input  logic [7:0]            cmd_data,
    input  logic                  ld_we,
    input  logic [CH_W-1:0]       ld_ch,
    input  logic                  ld_is_cnt,
    input  logic [LDW-1:0]        ld_data,
    input  logic [NCH-1:0]        dack,
    input  logic [NCH-1:0]        dreq,
    output logic [NCH-1:0]        dreq_masked,
    output logic [NCH*MODE_W-1:0] ch_mode,
    output logic [NCH-1:0]        wr_en,
    output logic [NCH-1:0]        rd_en,
    output logic [NCH-1:0]        tc,
    output logic [NCH*AW-1:0]     cur_addr,
    output logic [NCH*CW-1:0]     cur_cnt
);
    logic [NCH-1:0] mask, stop, ch_armed;
    chmode_t        mode [NCH];

    dma4_cmd_regs #(.NCH(NCH)) u_regs (
        .clk(clk), .rst_n(rst_n), .mclr(mclr),
        .cmd_we(cmd_we), .cmd_sel(cmd_sel), .cmd_data(cmd_data),
        .stop(stop), .mask(mask), .mode(mode)
    );

    assign dreq_masked = dreq & ~mask;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic is_casc;

        dma4_chan #(.AW(AW), .CW(CW), .LDW(LDW)) u_chan (
            .clk(clk), .rst_n(rst_n), .mclr(mclr),
            .ld_we(ld_we && (ld_ch == CH_W'(i))),
            .ld_is_cnt(ld_is_cnt), .ld_data(ld_data),
            .ack(dack[i]), .dec(mode[i].dec), .autoinit(mode[i].autoinit),
            .cur_addr(cur_addr[i*AW +: AW]), .cur_cnt(cur_cnt[i*CW +: CW]),
            .tc(tc[i]), .stop(stop[i]), .armed(ch_armed[i])
        );

        assign is_casc = (mode[i].xmode == XM_CASCADE);
        assign wr_en[i] = !is_casc && (mode[i].xtype == XT_WRITE);
        assign rd_en[i] = !is_casc && (mode[i].xtype == XT_READ);
        assign ch_mode[i*MODE_W +: MODE_W] = mode[i];
    end
endmodule

// File: rtl/dma4_mode_ctrl_chk.sv
module dma4_mode_ctrl_chk
    import dma4_pkg::*;
#(
    parameter int NCH = 4,
    parameter int CW  = 16,
    localparam int CH_W = $clog2(NCH)
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  mclr,
    input logic                  cmd_we,
    input logic                  cmd_sel,
    input logic [7:0]            cmd_data,
    input logic                  ld_we,
    input logic [CH_W-1:0]       ld_ch,
    input logic [NCH-1:0]        dack,
    input logic [NCH-1:0]        dreq,
    input logic [NCH-1:0]        dreq_masked,
    input logic [NCH*MODE_W-1:0] ch_mode,
    input logic [NCH-1:0]        wr_en,
    input logic [NCH-1:0]        rd_en,
    input logic [NCH-1:0]        tc,
    input logic [NCH*CW-1:0]     cur_cnt,
    input logic [NCH-1:0]        ch_armed
);
    localparam logic [CW-1:0] ONE = CW'(1);

    p_mclr_masks_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(mclr) |-> (dreq_masked == '0 && ch_mode == '0));

    p_mask_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && !cmd_sel && cmd_data[2]) |=> !dreq_masked[$past(cmd_data[CH_W-1:0])]);

    // R3: an unmask with no acknowledge pending lets the raw request through
    p_unmask_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && !cmd_sel && !cmd_data[2] && dack == '0 && !mclr)
        |=> (dreq_masked[$past(cmd_data[CH_W-1:0])] == dreq[$past(cmd_data[CH_W-1:0])]));

    p_strobe_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en & rd_en) == '0);

    for (genvar i = 0; i < NCH; i++) begin : g_chk
        logic live, casc;
        assign live = dack[i] && ch_armed[i] && !mclr && !(ld_we && ld_ch == CH_W'(i));
        assign casc = (ch_mode[i*MODE_W+5 -: 2] == 2'b11);

        p_cnt_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (live && cur_cnt[i*CW +: CW] != '0)
            |=> (cur_cnt[i*CW +: CW] == $past(cur_cnt[i*CW +: CW]) - ONE && !tc[i]));

        p_tc_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (live && cur_cnt[i*CW +: CW] == '0) |=> tc[i]);

        p_stop_masks_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (live && cur_cnt[i*CW +: CW] == '0 && !ch_mode[i*MODE_W+2])
            |=> (!dreq_masked[i] && !ch_armed[i]));

        p_cascade_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
            casc |-> (!wr_en[i] && !rd_en[i]));
    end
endmodule

bind dma4_mode_ctrl dma4_mode_ctrl_chk #(.NCH(NCH), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .mclr(mclr), .cmd_we(cmd_we), .cmd_sel(cmd_sel),
    .cmd_data(cmd_data), .ld_we(ld_we), .ld_ch(ld_ch), .dack(dack), .dreq(dreq),
    .dreq_masked(dreq_masked), .ch_mode(ch_mode), .wr_en(wr_en), .rd_en(rd_en),
    .tc(tc), .cur_cnt(cur_cnt), .ch_armed(ch_armed)
);

// File: tb/tb_dma4_mode_ctrl.sv
module tb_dma4_mode_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mclr = 1'b0;
    logic        cmd_we = 1'b0;
    logic        cmd_sel = 1'b0;
    logic [7:0]  cmd_data = '0;
    logic        ld_we = 1'b0;
    logic [1:0]  ld_ch = '0;
    logic        ld_is_cnt = 1'b0;
    logic [15:0] ld_data = '0;
    logic [3:0]  dack = '0;
    logic [3:0]  dreq = 4'hF;
    logic [3:0]  dreq_masked, wr_en, rd_en, tc;
    logic [23:0] ch_mode;
    logic [63:0] cur_addr, cur_cnt;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    dma4_mode_ctrl dut (
        .clk(clk), .rst_n(rst_n), .mclr(mclr), .cmd_we(cmd_we), .cmd_sel(cmd_sel),
        .cmd_data(cmd_data), .ld_we(ld_we), .ld_ch(ld_ch), .ld_is_cnt(ld_is_cnt),
        .ld_data(ld_data), .dack(dack), .dreq(dreq), .dreq_masked(dreq_masked),
        .ch_mode(ch_mode), .wr_en(wr_en), .rd_en(rd_en), .tc(tc),
        .cur_addr(cur_addr), .cur_cnt(cur_cnt)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cmd(input logic kind, input logic [7:0] data);
        @(negedge clk);
        cmd_we = 1'b1; cmd_sel = kind; cmd_data = data;
        @(negedge clk);
        cmd_we = 1'b0;
    endtask

    task automatic load(input int ch, input logic is_cnt, input logic [15:0] val);
        @(negedge clk);
        ld_we = 1'b1; ld_ch = 2'(ch); ld_is_cnt = is_cnt; ld_data = val;
        @(negedge clk);
        ld_we = 1'b0;
    endtask

    task automatic ack(input int ch);
        @(negedge clk);
        dack = 4'(1 << ch);
        @(negedge clk);
        dack = '0;
    endtask

    function automatic logic [15:0] addr_of(input int ch);
        return cur_addr[ch*16 +: 16];
    endfunction

    function automatic logic [15:0] cnt_of(input int ch);
        return cur_cnt[ch*16 +: 16];
    endfunction

    task automatic t_reset;
        check("R1 reset masks", dreq_masked, 4'h0);
        check("R1 reset modes", ch_mode, 24'h0);
        check("R1 reset wr_en", wr_en, 4'h0);
        check("R1 reset rd_en", rd_en, 4'h0);
        check("R1 reset tc", tc, 4'h0);
    endtask

    task automatic t_mask;
        cmd(1'b0, 8'b0000_0010);
        check("R2 unmask ch2 only", dreq_masked, 4'b0100);
        cmd(1'b0, 8'b0000_0000);
        check("R2 unmask ch0 keeps ch2", dreq_masked, 4'b0101);
        cmd(1'b0, 8'b0000_0110);
        check("R2 mask ch2 keeps ch0", dreq_masked, 4'b0001);
        @(negedge clk); dreq = 4'b0000; #1;
        check("R3 no raw request", dreq_masked, 4'b0000);
        dreq = 4'hF;
    endtask

    task automatic t_mode;
        cmd(1'b1, 8'h45);
        check("R4 ch1 mode stored", ch_mode[11:6], 6'b010001);
        check("R4 other modes untouched", {ch_mode[23:12], ch_mode[5:0]}, 18'h0);
        check("R10 write type", wr_en, 4'b0010);
        cmd(1'b1, 8'h4B);
        check("R10 read type", rd_en, 4'b1000);
        cmd(1'b1, 8'hCB);
        check("R10 cascade hides read", rd_en, 4'b0000);
        check("R4 cascade stored", ch_mode[23:18], 6'b110010);
        cmd(1'b1, 8'h4C);
        check("R10 illegal stored", ch_mode[5:0], 6'b010011);
        check("R10 illegal no strobe", {wr_en[0], rd_en[0]}, 2'b00);
        check("R4 ch1 kept", ch_mode[11:6], 6'b010001);
    endtask

    task automatic t_inc;
        cmd(1'b1, 8'h44);
        load(0, 1'b0, 16'h1000);
        load(0, 1'b1, 16'h0003);
        check("R5 address loaded", addr_of(0), 16'h1000);
        check("R5 count loaded", cnt_of(0), 16'h0003);
        ack(0);
        check("R6 inc addr", addr_of(0), 16'h1001);
        check("R6 count step", cnt_of(0), 16'h0002);
        ack(0);
        check("R6 inc addr again", addr_of(0), 16'h1002);
        check("R6 count again", cnt_of(0), 16'h0001);
        check("R7 no tc yet", tc, 4'h0);
    endtask

    task automatic t_dec;
        cmd(1'b1, 8'h65);
        load(1, 1'b0, 16'h2000);
        load(1, 1'b1, 16'h0005);
        ack(1);
        check("R6 dec addr", addr_of(1), 16'h1FFF);
        check("R6 dec count", cnt_of(1), 16'h0004);
    endtask

    task automatic t_autoinit;
        cmd(1'b1, 8'h56);
        cmd(1'b0, 8'b0000_0010);
        load(2, 1'b0, 16'h3000);
        load(2, 1'b1, 16'h0001);
        ack(2);
        check("R6 ch2 addr", addr_of(2), 16'h3001);
        check("R6 ch2 count", cnt_of(2), 16'h0000);
        ack(2);
        check("R7 tc on ch2", tc, 4'b0100);
        check("R8 addr reloaded", addr_of(2), 16'h3000);
        check("R8 count reloaded", cnt_of(2), 16'h0001);
        check("R8 mask kept open", dreq_masked[2], 1'b1);
        @(negedge clk);
        check("R7 tc one cycle", tc, 4'h0);
    endtask

    task automatic t_stop;
        cmd(1'b1, 8'h47);
        cmd(1'b0, 8'b0000_0011);
        load(3, 1'b0, 16'h4000);
        load(3, 1'b1, 16'h0000);
        check("R3 ch3 requesting", dreq_masked[3], 1'b1);
        ack(3);
        check("R7 tc on ch3", tc, 4'b1000);
        check("R9 count wraps", cnt_of(3), 16'hFFFF);
        check("R9 addr steps", addr_of(3), 16'h4001);
        check("R9 self mask", dreq_masked[3], 1'b0);
        ack(3);
        check("R9 expired addr held", addr_of(3), 16'h4001);
        check("R9 expired count held", cnt_of(3), 16'hFFFF);
        check("R9 expired no tc", tc, 4'h0);
        load(3, 1'b1, 16'h0002);
        cmd(1'b0, 8'b0000_0011);
        ack(3);
        check("R9 rearmed count", cnt_of(3), 16'h0001);
        check("R9 rearmed request", dreq_masked[3], 1'b1);
    endtask

    task automatic t_mclr;
        @(negedge clk); mclr = 1'b1;
        @(negedge clk); mclr = 1'b0;
        check("R1 mclr masks", dreq_masked, 4'h0);
        check("R1 mclr modes", ch_mode, 24'h0);
        check("R1 mclr strobes", {wr_en, rd_en}, 8'h0);
        ack(0);
        check("R1 mclr increment", addr_of(0), 16'h1003);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_mask;
        t_mode;
        t_inc;
        t_dec;
        t_autoinit;
        t_stop;
        t_mclr;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule